// File: doc/BRIEF.md
# Relation Vector Comparator

This block compares two 64-bit operands and returns one wide result word in which every relation the comparator can determine sits in its own bit. The caller does not pick a condition before the compare. It issues one compare, keeps the word, and a later branch or predicate tests whichever single bit it needs. A mode input selects how the operands are read: as integers, or as IEEE-754 double-precision values.

In integer mode the word holds equality, the signed and unsigned orderings, and a range check. In floating-point mode it holds the ordered relations, an unordered flag, the range check, and a ten-way class of operand A. Each class has its own bit. The result is registered and appears one clock after a valid input, together with an output valid flag.

Top module: `cmp_vector_unit`

## Requirements
- R1: While reset (`rst_n` low) is applied and on the first cycle after it, `out_vld` is 0 and `out_vec` is all zero.
- R2: When `in_vld` is 1 at a clock edge, `out_vld` is 1 in the next cycle and `out_vec` holds that compare's result. When `in_vld` is 0, `out_vld` is 0 in the next cycle and `out_vec` keeps its previous value, whatever the operands do.
- R3: In integer mode (`in_fp`=0), bit 0 (EQ) is set when A equals B, and bit 1 (NE) is set when A differs from B. Exactly one of the two is set.
- R4: In integer mode, bits 2..5 report the two's-complement signed relations: bit 2 LT (A<B), bit 3 LE (A<=B), bit 4 GT (A>B), bit 5 GE (A>=B).
- R5: In integer mode, bits 6..9 report the unsigned relations: bit 6 ULT, bit 7 ULE, bit 8 UGT, bit 9 UGE. In floating-point mode these four bits are 0.
- R6: Bit 10 (RNG) is set when 0 < A <= B. In integer mode the test uses signed comparison.
- R7: In integer mode, bits 11..21 are all 0.
- R8: In floating-point mode, exactly one of bits 12..21 is set, giving the class of A:
  - bit 12: -inf
  - bit 13: -normal
  - bit 14: -denormal
  - bit 15: -zero
  - bit 16: +zero
  - bit 17: +denormal
  - bit 18: +normal
  - bit 19: +inf
  - bit 20: signalling NaN (exponent all ones, fraction non-zero, fraction MSB 0)
  - bit 21: quiet NaN (exponent all ones, fraction MSB 1)
- R9: In floating-point mode with neither operand a NaN, bits 0..5 report the ordered relations EQ, NE, LT, LE, GT, GE, and +0 compares equal to -0.
- R10: In floating-point mode with either operand a NaN, bit 11 (UNORD) is 1 and bits 0..10 are all 0. Bit 11 is 0 whenever neither operand is a NaN.
- R11: In floating-point mode, RNG is set only when neither operand is a NaN, A is greater than zero (either zero fails), and A <= B under the ordered comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| in_fp | input | 1 | 1: double-precision floating-point mode, 0: integer mode |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| out_vld | output | 1 | `out_vec` holds a new result this cycle |
| out_vec | output | 22 | Relation and class vector |

## Verification
The only state in this block is the result register and its valid flag. A wrong captured value shows on `out_vec` in the very cycle `out_vld` rises, and a wrong hold shows in the cycle after an idle input. Because of that, each stimulus is checked one cycle after it is applied, and idle cycles with changing operands check that nothing leaks through.

Errors that depend on the data appear only for particular operand pairs. The stimulus therefore covers:
- signed and unsigned orderings that disagree,
- both signs of zero,
- denormals, infinities and both NaN kinds on either side,
- the edges of the range check.

// File: rtl/cmpv_pkg.sv
package cmpv_pkg;

    localparam int RES_W = 22;

    localparam int B_EQ    = 0;
    localparam int B_NE    = 1;
    localparam int B_LT    = 2;
    localparam int B_LE    = 3;
    localparam int B_GT    = 4;
    localparam int B_GE    = 5;
    localparam int B_ULT   = 6;
    localparam int B_ULE   = 7;
    localparam int B_UGT   = 8;
    localparam int B_UGE   = 9;
    localparam int B_RNG   = 10;
    localparam int B_UNORD = 11;
    localparam int B_CLS   = 12;
    localparam int N_CLS   = 10;

    // class index order inside the class field
    typedef enum logic [3:0] {
        CL_NINF  = 4'd0,
        CL_NNORM = 4'd1,
        CL_NDEN  = 4'd2,
        CL_NZERO = 4'd3,
        CL_PZERO = 4'd4,
        CL_PDEN  = 4'd5,
        CL_PNORM = 4'd6,
        CL_PINF  = 4'd7,
        CL_SNAN  = 4'd8,
        CL_QNAN  = 4'd9
    } cmpv_cls_e;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] vec;
    } cmpv_state_t;

endpackage

// File: rtl/cmpv_int_rel.sv
module cmpv_int_rel #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              eq,
    output logic              slt,
    output logic              ult,
    output logic              a_pos
);
    always_comb begin
        eq    = (a == b);
        slt   = ($signed(a) < $signed(b));
        ult   = (a < b);
        a_pos = !a[DATA_W-1] && (a != '0);
    end
endmodule

// File: rtl/cmpv_fp_class.sv
module cmpv_fp_class
    import cmpv_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] x,
    output logic [N_CLS-1:0]  cls,
    output logic              is_nan,
    output logic              is_zero
);
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;
    cmpv_cls_e         sel;

    always_comb begin
        sgn     = x[DATA_W-1];
        ex      = x[DATA_W-2 -: EXP_W];
        fr      = x[FRAC_W-1:0];
        is_nan  = 1'b0;
        is_zero = 1'b0;
        if (&ex) begin
            if (fr == '0) begin
                sel = sgn ? CL_NINF : CL_PINF;
            end else begin
                is_nan = 1'b1;
                sel    = fr[FRAC_W-1] ? CL_QNAN : CL_SNAN;
            end
        end else if (ex == '0) begin
            if (fr == '0) begin
                is_zero = 1'b1;
                sel     = sgn ? CL_NZERO : CL_PZERO;
            end else begin
                sel = sgn ? CL_NDEN : CL_PDEN;
            end
        end else begin
            sel = sgn ? CL_NNORM : CL_PNORM;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_CLS; gi++) begin : g_dec
            assign cls[gi] = (sel == cmpv_cls_e'(gi));
        end
    endgenerate
endmodule

// File: rtl/cmpv_fp_rel.sv
module cmpv_fp_rel #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              a_nan,
    input  logic              b_nan,
    input  logic              a_zero,
    input  logic              b_zero,
    output logic              unord,
    output logic              feq,
    output logic              flt,
    output logic              a_pos
);
    logic [DATA_W-1:0] ka;
    logic [DATA_W-1:0] kb;

    // map sign-magnitude onto an unsigned order
    always_comb begin
        ka    = a[DATA_W-1] ? ~a : {1'b1, a[DATA_W-2:0]};
        kb    = b[DATA_W-1] ? ~b : {1'b1, b[DATA_W-2:0]};
        unord = a_nan || b_nan;
        if (unord) begin
            feq = 1'b0;
            flt = 1'b0;
        end else if (a_zero && b_zero) begin
            feq = 1'b1;
            flt = 1'b0;
        end else begin
            feq = (ka == kb);
            flt = (ka < kb);
        end
        a_pos = !a_nan && !a_zero && !a[DATA_W-1];
    end
endmodule

// File: rtl/cmp_vector_unit.sv
module cmp_vector_unit
    import cmpv_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_fp,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_vld,
    output logic [RES_W-1:0]  out_vec
);
    logic             i_eq, i_slt, i_ult, i_apos;
    logic [N_CLS-1:0] a_cls;
    logic [N_CLS-1:0] b_cls_unused;
    logic             a_nan, a_zero, b_nan, b_zero;
    logic             f_unord, f_eq, f_lt, f_apos;
    cmpv_state_t      st_d, st_q;

    cmpv_int_rel #(.DATA_W(DATA_W)) u_int (
        .a(op_a), .b(op_b), .eq(i_eq), .slt(i_slt), .ult(i_ult), .a_pos(i_apos)
    );

    cmpv_fp_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .x(op_a), .cls(a_cls), .is_nan(a_nan), .is_zero(a_zero)
    );

    cmpv_fp_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .x(op_b), .cls(b_cls_unused), .is_nan(b_nan), .is_zero(b_zero)
    );

    cmpv_fp_rel #(.DATA_W(DATA_W)) u_frel (
        .a(op_a), .b(op_b), .a_nan(a_nan), .b_nan(b_nan),
        .a_zero(a_zero), .b_zero(b_zero),
        .unord(f_unord), .feq(f_eq), .flt(f_lt), .a_pos(f_apos)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.vec = '0;
            if (in_fp) begin
                if (!f_unord) begin
                    st_d.vec[B_EQ]  = f_eq;
                    st_d.vec[B_NE]  = !f_eq;
                    st_d.vec[B_LT]  = f_lt;
                    st_d.vec[B_LE]  = f_lt || f_eq;
                    st_d.vec[B_GT]  = !f_lt && !f_eq;
                    st_d.vec[B_GE]  = !f_lt;
                    st_d.vec[B_RNG] = f_apos && (f_lt || f_eq);
                end
                st_d.vec[B_UNORD]               = f_unord;
                st_d.vec[B_CLS +: N_CLS]        = a_cls;
            end else begin
                st_d.vec[B_EQ]  = i_eq;
                st_d.vec[B_NE]  = !i_eq;
                st_d.vec[B_LT]  = i_slt;
                st_d.vec[B_LE]  = i_slt || i_eq;
                st_d.vec[B_GT]  = !i_slt && !i_eq;
                st_d.vec[B_GE]  = !i_slt;
                st_d.vec[B_ULT] = i_ult;
                st_d.vec[B_ULE] = i_ult || i_eq;
                st_d.vec[B_UGT] = !i_ult && !i_eq;
                st_d.vec[B_UGE] = !i_ult;
                st_d.vec[B_RNG] = i_apos && (i_slt || i_eq);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_vec = st_q.vec;
endmodule

// File: rtl/cmpv_checker.sv
module cmpv_checker
    import cmpv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_fp,
    input logic             out_vld,
    input logic [RES_W-1:0] out_vec
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_vec == '0));

    assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_vec)));

    assert_eq_ne_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_fp) |=> (out_vec[B_EQ] != out_vec[B_NE]));

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($countones({out_vec[B_LT], out_vec[B_EQ], out_vec[B_GT]}) <= 1));

    assert_int_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_fp) |=> (out_vec[RES_W-1:B_UNORD] == '0));

    assert_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_fp) |=> ($countones(out_vec[B_CLS +: N_CLS]) == 1));

    assert_unord_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_vec[B_UNORD]) |-> (out_vec[B_RNG:0] == '0));
endmodule

bind cmp_vector_unit cmpv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fp(in_fp),
    .out_vld(out_vld), .out_vec(out_vec)
);

// File: tb/sim_cmp_vector_unit.sv
module sim_cmp_vector_unit;
    localparam int W  = 64;
    localparam int RW = 22;
    localparam int NV = 20;

    localparam logic [RW-1:0] EQ = 22'h1 << 0,  NE = 22'h1 << 1;
    localparam logic [RW-1:0] LT = 22'h1 << 2,  LE = 22'h1 << 3;
    localparam logic [RW-1:0] GT = 22'h1 << 4,  GE = 22'h1 << 5;
    localparam logic [RW-1:0] ULT = 22'h1 << 6, ULE = 22'h1 << 7;
    localparam logic [RW-1:0] UGT = 22'h1 << 8, UGE = 22'h1 << 9;
    localparam logic [RW-1:0] RNG = 22'h1 << 10, UNO = 22'h1 << 11;
    localparam logic [RW-1:0] C_NINF = 22'h1 << 12, C_NNORM = 22'h1 << 13;
    localparam logic [RW-1:0] C_NDEN = 22'h1 << 14, C_NZERO = 22'h1 << 15;
    localparam logic [RW-1:0] C_PZERO = 22'h1 << 16, C_PDEN = 22'h1 << 17;
    localparam logic [RW-1:0] C_PNORM = 22'h1 << 18, C_PINF = 22'h1 << 19;
    localparam logic [RW-1:0] C_SNAN = 22'h1 << 20, C_QNAN = 22'h1 << 21;

    localparam logic [W-1:0] ONE  = 64'h3FF0000000000000;
    localparam logic [W-1:0] TWO  = 64'h4000000000000000;
    localparam logic [W-1:0] MONE = 64'hBFF0000000000000;
    localparam logic [W-1:0] MTWO = 64'hC000000000000000;
    localparam logic [W-1:0] PZ   = 64'h0;
    localparam logic [W-1:0] NZ   = 64'h8000000000000000;
    localparam logic [W-1:0] PINF = 64'h7FF0000000000000;
    localparam logic [W-1:0] NINF = 64'hFFF0000000000000;
    localparam logic [W-1:0] QNAN = 64'h7FF8000000000000;
    localparam logic [W-1:0] SNAN = 64'h7FF0000000000001;
    localparam logic [W-1:0] PDEN = 64'h0000000000000001;
    localparam logic [W-1:0] NDEN = 64'h8000000000000001;

    // {fp, a, b, expected}
    localparam logic [1+2*W+RW-1:0] TBL [NV] = '{
        {1'b0, 64'd5, 64'd5, EQ|LE|GE|ULE|UGE|RNG},
        {1'b0, 64'd3, 64'd7, NE|LT|LE|ULT|ULE|RNG},
        {1'b0, 64'hFFFFFFFFFFFFFFFF, 64'd1, NE|LT|LE|UGT|UGE},
        {1'b0, 64'd0, 64'd0, EQ|LE|GE|ULE|UGE},
        {1'b0, 64'd9, 64'd2, NE|GT|GE|UGT|UGE},
        {1'b0, 64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, NE|LT|LE|UGT|UGE},
        {1'b0, 64'hFFFFFFFFFFFFFFFD, 64'hFFFFFFFFFFFFFFFF, NE|LT|LE|ULT|ULE},
        {1'b1, ONE, TWO, NE|LT|LE|RNG|C_PNORM},
        {1'b1, TWO, ONE, NE|GT|GE|C_PNORM},
        {1'b1, NZ, PZ, EQ|LE|GE|C_NZERO},
        {1'b1, PZ, NZ, EQ|LE|GE|C_PZERO},
        {1'b1, QNAN, ONE, UNO|C_QNAN},
        {1'b1, ONE, SNAN, UNO|C_PNORM},
        {1'b1, SNAN, SNAN, UNO|C_SNAN},
        {1'b1, NINF, MONE, NE|LT|LE|C_NINF},
        {1'b1, PINF, PINF, EQ|LE|GE|RNG|C_PINF},
        {1'b1, PDEN, ONE, NE|LT|LE|RNG|C_PDEN},
        {1'b1, NDEN, PZ, NE|LT|LE|C_NDEN},
        {1'b1, MONE, MTWO, NE|GT|GE|C_NNORM},
        {1'b1, ONE, ONE, EQ|LE|GE|RNG|C_PNORM}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic          in_fp = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          out_vld;
    logic [RW-1:0] out_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cmp_vector_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fp(in_fp),
        .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .out_vec(out_vec)
    );

    task automatic check(input string req, input logic [RW:0] act, input logic [RW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic fp, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [RW-1:0] exp, input string req);
        @(negedge clk);
        in_vld = 1'b1; in_fp = fp; op_a = a; op_b = b;
        @(negedge clk);
        in_vld = 1'b0;
        check(req, {out_vld, out_vec}, {1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {out_vld, out_vec}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_vld, out_vec}, '0);

        // table walk: R3 R4 R5 R6 R7 (int rows), R8 R9 R10 R11 (fp rows)
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i][1+2*W+RW-1], TBL[i][2*W+RW-1 -: W], TBL[i][W+RW-1 -: W],
                  TBL[i][RW-1:0], TBL[i][1+2*W+RW-1] ? "R8/R9/R10/R11 fp row" : "R3/R4/R5/R6/R7 int row");
        end

        // R2: idle cycle with changing operands holds the vector
        @(negedge clk);
        in_fp = 1'b0; op_a = 64'd1; op_b = 64'd0;
        @(negedge clk);
        check("R2 hold", {out_vld, out_vec}, {1'b0, EQ|LE|GE|RNG|C_PNORM});

        // R2: back-to-back valid inputs
        @(negedge clk);
        in_vld = 1'b1; in_fp = 1'b0; op_a = 64'd4; op_b = 64'd4;
        @(negedge clk);
        check("R2 b2b first", {out_vld, out_vec}, {1'b1, EQ|LE|GE|ULE|UGE|RNG});
        in_fp = 1'b1; op_a = NINF; op_b = QNAN;
        @(negedge clk);
        in_vld = 1'b0;
        check("R2 b2b second R10", {out_vld, out_vec}, {1'b1, UNO|C_NINF});

        // R11: negative A fails range even with A <= B
        apply(1'b1, MTWO, ONE, NE|LT|LE|C_NNORM, "R11 negative A");
        // R6: A equal to B at top of range, signed max
        apply(1'b0, 64'h7FFFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFFFF, EQ|LE|GE|ULE|UGE|RNG, "R6 max edge");

        // R1: reset clears a held result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {out_vld, out_vec}, '0);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule